// File: doc/BRIEF.md
# Shared-Period Input Debounce Filter

This block cleans up to 32 already-synchronized input levels before they reach value and interrupt logic. It does not give each pin its own period. Three programmable period registers are shared by all pins, and each holds a length in clock cycles. Every pin carries a 2-bit selection code. Code 0 passes the pin through untouched. Codes 1 to 3 tie the pin to one of the three shared periods. Any number of pins may use the same period at the same time, and each pin keeps its own counter.

Software programs the block through a simple write-only port that addresses five words. Two of them are selection words. Each holds one bit of every pin's code at the pin's bit position. The other three are the period words. Writes are accepted in any cycle and are never blocked or deferred.

A debounced pin changes its output only after the raw level has differed from the output for a full period of consecutive samples. A return to the old level during that window cancels the pending change. The period in effect is the one read when the pin starts qualifying a new level.

Top module: `dbn_shared_filter`

## Requirements
- R1: After reset, all selection codes and periods are zero and every output equals its raw input in the same cycle.
- R2: A write with `wr_en` high is taken at the clock edge. Address 0 loads the selection high word and address 1 loads the selection low word. Addresses 2, 3 and 4 load periods 1, 2 and 3. Pin i's code is {high word bit i, low word bit i}, and code k (1..3) uses period k.
- R3: A pin with code 0 drives its output from its raw input combinationally, with no clock delay.
- R4: For a pin with code k and period P ≥ 1, the output takes a new raw level at the clock edge that samples that level for the P-th consecutive time. The change is visible right after that edge.
- R5: If the raw level returns to the output level before qualification completes, the pending change is dropped. The next differing sample starts a full new count.
- R6: A selected period of 0 acts exactly like a period of 1. The output follows a change at the first clock edge that samples it.
- R7: Pins sharing one period register qualify independently. Each pin's change lands P edges after its own first differing sample.
- R8: A write to a period register does not alter a qualification already in progress. It takes effect for qualifications that start afterwards.
- R9: Writes to addresses 5, 6 and 7 change no selection or period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register word address |
| wr_data | input | 32 | Register write data |
| raw_i | input | 32 | Synchronized raw pin levels |
| filt_o | output | 32 | Debounced pin levels |

## Verification
Several properties are checked on every cycle:
- A pass-through pin's held state tracks its raw level.
- A lane that sees raw equal to its output holds its output.
- A bounce clears the armed flag.
- An armed counter never reaches zero.
- The zero-or-one period updates on the next edge.
- Period writes land.
- Unused addresses change nothing.

Only the bench scenarios can show the exact edge on which a qualified level emerges for a given period. The same applies to comparing pins that share a period with pins on other periods, and to showing that a period rewritten mid-count leaves the running count alone.

// File: rtl/dbn_pkg.sv
`timescale 1ns/1ps
package dbn_pkg;
  localparam int ADDR_W    = 3;
  localparam int N_TIMERS  = 3;
  localparam int CODE_W    = 2;

  typedef logic [CODE_W-1:0] dbn_code_t;

  localparam dbn_code_t CODE_BYPASS = 2'd0;
  localparam dbn_code_t CODE_PER1   = 2'd1;
  localparam dbn_code_t CODE_PER2   = 2'd2;
  localparam dbn_code_t CODE_PER3   = 2'd3;

  localparam logic [ADDR_W-1:0] ADDR_SEL_HI   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_SEL_LO   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_PER_BASE = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_PER_LAST = ADDR_PER_BASE + ADDR_W'(N_TIMERS - 1);
endpackage

// File: rtl/dbn_regs.sv
`timescale 1ns/1ps
module dbn_regs
  import dbn_pkg::*;
#(
  parameter int N_PINS = 32,
  parameter int PER_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [DATA_W-1:0]                wr_data,
  output logic [N_PINS-1:0]                sel_hi_o,
  output logic [N_PINS-1:0]                sel_lo_o,
  output logic [N_TIMERS-1:0][PER_W-1:0]   per_o
);

  logic [N_PINS-1:0] hi_q, hi_d, lo_q, lo_d;
  logic              hi_en, lo_en;

  always_comb begin
    hi_en = wr_en && (wr_addr == ADDR_SEL_HI);
    lo_en = wr_en && (wr_addr == ADDR_SEL_LO);
    hi_d  = wr_data[N_PINS-1:0];
    lo_d  = wr_data[N_PINS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (hi_en) hi_q <= hi_d;
      if (lo_en) lo_q <= lo_d;
    end
  end

  logic [N_TIMERS-1:0][PER_W-1:0] per_q;

  for (genvar t = 0; t < N_TIMERS; t++) begin : g_per
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_PER_BASE + ADDR_W'(t);
    logic             per_en;
    logic [PER_W-1:0] per_d;

    always_comb begin
      per_en = wr_en && (wr_addr == MY_ADDR);
      per_d  = wr_data[PER_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      per_q[t] <= '0;
      else if (per_en) per_q[t] <= per_d;
    end

    AST_PER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == MY_ADDR) |=> per_q[t] == $past(wr_data[PER_W-1:0])); // R2
  end

  assign sel_hi_o = hi_q;
  assign sel_lo_o = lo_q;
  assign per_o    = per_q;

  AST_UNUSED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr > ADDR_PER_LAST) |=> ($stable(per_q) && $stable(hi_q) && $stable(lo_q))); // R9

endmodule

// File: rtl/dbn_pick.sv
`timescale 1ns/1ps
module dbn_pick
  import dbn_pkg::*;
#(
  parameter int PER_W = 32
) (
  input  dbn_code_t                       code_i,
  input  logic [N_TIMERS-1:0][PER_W-1:0]  per_i,
  output logic                            bypass_o,
  output logic [PER_W-1:0]                per_o
);

  always_comb begin
    bypass_o = 1'b0;
    per_o    = '0;
    case (code_i)
      CODE_PER1: per_o = per_i[0];
      CODE_PER2: per_o = per_i[1];
      CODE_PER3: per_o = per_i[2];
      default:   bypass_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/dbn_lane.sv
`timescale 1ns/1ps
module dbn_lane #(
  parameter int PER_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw_i,
  input  logic             bypass_i,
  input  logic [PER_W-1:0] period_i,
  output logic             filt_o
);

  localparam logic [PER_W-1:0] ONE = PER_W'(1);

  logic             filt_q, filt_d;
  logic             armed_q, armed_d;
  logic [PER_W-1:0] cnt_q, cnt_d;
  logic             filt_en, cnt_en, armed_en;

  always_comb begin
    filt_d  = filt_q;
    armed_d = armed_q;
    cnt_d   = cnt_q;
    if (bypass_i) begin
      filt_d  = raw_i;
      armed_d = 1'b0;
    end else if (raw_i == filt_q) begin
      armed_d = 1'b0;
    end else if (!armed_q) begin
      if (period_i <= ONE) begin
        filt_d = raw_i;
      end else begin
        armed_d = 1'b1;
        cnt_d   = period_i - ONE;
      end
    end else if (cnt_q <= ONE) begin
      filt_d  = raw_i;
      armed_d = 1'b0;
    end else begin
      cnt_d = cnt_q - ONE;
    end
    filt_en  = (filt_d != filt_q);
    armed_en = (armed_d != armed_q);
    cnt_en   = (cnt_d != cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q  <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      if (filt_en)  filt_q  <= filt_d;
      if (armed_en) armed_q <= armed_d;
      if (cnt_en)   cnt_q   <= cnt_d;
    end
  end

  assign filt_o = bypass_i ? raw_i : filt_q;

  AST_BYPASS_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_i |=> filt_q == $past(raw_i)); // R3

  AST_HOLD_WHEN_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass_i && raw_i == filt_q) |=> $stable(filt_q)); // R5

  AST_BOUNCE_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass_i && armed_q && raw_i == filt_q) |=> !armed_q); // R5

  AST_ARMED_CNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> cnt_q != '0); // R4

  AST_SHORT_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass_i && !armed_q && raw_i != filt_q && period_i <= ONE) |=> filt_q == $past(raw_i)); // R6

endmodule

// File: rtl/dbn_shared_filter.sv
`timescale 1ns/1ps
module dbn_shared_filter
  import dbn_pkg::*;
#(
  parameter int N_PINS = 32,
  parameter int PER_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [N_PINS-1:0] raw_i,
  output logic [N_PINS-1:0] filt_o
);

  logic [N_PINS-1:0]              sel_hi, sel_lo;
  logic [N_TIMERS-1:0][PER_W-1:0] per;

  dbn_regs #(
    .N_PINS (N_PINS),
    .PER_W  (PER_W),
    .DATA_W (DATA_W)
  ) regs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .sel_hi_o (sel_hi),
    .sel_lo_o (sel_lo),
    .per_o    (per)
  );

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    dbn_code_t        code;
    logic             bypass;
    logic [PER_W-1:0] period;

    assign code = {sel_hi[p], sel_lo[p]};

    dbn_pick #(.PER_W(PER_W)) pick_i (
      .code_i   (code),
      .per_i    (per),
      .bypass_o (bypass),
      .per_o    (period)
    );

    dbn_lane #(.PER_W(PER_W)) lane_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw_i    (raw_i[p]),
      .bypass_i (bypass),
      .period_i (period),
      .filt_o   (filt_o[p])
    );
  end

endmodule

// File: tb/dbn_shared_filter_tb.sv
`timescale 1ns/1ps
module dbn_shared_filter_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [31:0] wr_data;
  logic [31:0] raw_in;
  logic [31:0] filt_out;

  always #2 clk = ~clk;

  dbn_shared_filter dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .raw_i   (raw_in),
    .filt_o  (filt_out)
  );

  int    checks = 0;
  int    errors = 0;
  int    cyc    = 0;
  bit    cmp_on = 0;
  string cur_req = "R1";

  // Behavioural reference: count consecutive differing samples per pin.
  bit [31:0] m_hi, m_lo;
  longint    m_per [3];
  bit        m_filt [32];
  longint    m_run  [32];
  longint    m_lim  [32];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hi = 0; m_lo = 0;
      for (int t = 0; t < 3; t++) m_per[t] = 0;
      for (int p = 0; p < 32; p++) begin m_filt[p] = 0; m_run[p] = 0; m_lim[p] = 1; end
    end else begin
      for (int p = 0; p < 32; p++) begin
        int code;
        code = {m_hi[p], m_lo[p]};
        if (code == 0) begin
          m_filt[p] = raw_in[p];
          m_run[p]  = 0;
        end else if (raw_in[p] != m_filt[p]) begin
          if (m_run[p] == 0) m_lim[p] = (m_per[code-1] < 1) ? 1 : m_per[code-1];
          m_run[p]++;
          if (m_run[p] >= m_lim[p]) begin
            m_filt[p] = raw_in[p];
            m_run[p]  = 0;
          end
        end else begin
          m_run[p] = 0;
        end
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_hi = wr_data;
          3'd1: m_lo = wr_data;
          3'd2, 3'd3, 3'd4: m_per[int'(wr_addr) - 2] = longint'(wr_data);
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      logic [31:0] e;
      for (int p = 0; p < 32; p++)
        e[p] = ({m_hi[p], m_lo[p]} == 2'd0) ? raw_in[p] : m_filt[p];
      checks++;
      if (filt_out !== e) begin
        errors++;
        $display("FAIL %s cycle %0d: filt_o got %h expected %h", cur_req, cyc, filt_out, e);
      end
    end
  end

  task automatic chk(input string req, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    raw_in = 32'hA5C3_1E77;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "output during reset", filt_out[5], raw_in[5]);
    @(posedge clk); #1;
    rst_n = 1'b1; cmp_on = 1; raw_in = 32'h3C00_F00F;
    @(negedge clk);
    chk("R1", "pin 0 after reset", filt_out[0], 1'b1);
    chk("R1", "pin 4 after reset", filt_out[4], 1'b0);

    cur_req = "R3";
    for (int i = 0; i < 20; i++) begin
      tick(1);
      raw_in = $urandom;
      @(negedge clk);
      chk("R3", "bypass same cycle pin 9", filt_out[9], raw_in[9]);
    end

    // periods 5, 3, 8; pin0 code1, pin1 code2, pin2 code3, pin3 code0, pins4..7 code2
    cur_req = "R2";
    tick(1); raw_in = '0;
    wr(3'd2, 32'd5);
    wr(3'd3, 32'd3);
    wr(3'd4, 32'd8);
    wr(3'd0, 32'h0000_00F6);
    wr(3'd1, 32'h0000_0005);
    tick(2);

    cur_req = "R4";
    raw_in[1:0] = 2'b11; raw_in[3] = 1'b1;
    @(negedge clk);
    chk("R2", "code0 pin 3 passes through", filt_out[3], 1'b1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R2", "code2 pin uses period 2", filt_out[1], 1'b1);
    chk("R4", "pin 0 before fifth edge", filt_out[0], 1'b0);
    @(posedge clk); @(negedge clk);
    chk("R4", "pin 0 after fourth edge", filt_out[0], 1'b0);
    @(posedge clk); @(negedge clk);
    chk("R4", "pin 0 after fifth edge", filt_out[0], 1'b1);
    tick(1); raw_in[3:0] = '0;
    tick(10);

    cur_req = "R5";
    raw_in[1] = 1'b1;
    repeat (2) @(posedge clk); #1;
    raw_in[1] = 1'b0;
    @(posedge clk); #1;
    raw_in[1] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R5", "count restarted after bounce", filt_out[1], 1'b0);
    @(posedge clk); @(negedge clk);
    chk("R5", "level after full recount", filt_out[1], 1'b1);
    tick(1); raw_in[1] = 1'b0;
    tick(6);

    cur_req = "R7";
    raw_in[4] = 1'b1;
    tick(1); raw_in[5] = 1'b1;
    tick(1); raw_in[6] = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R7", "pin 4 qualified", filt_out[4], 1'b1);
    chk("R7", "pin 5 still counting", filt_out[5], 1'b0);
    @(posedge clk); @(negedge clk);
    chk("R7", "pin 5 qualified", filt_out[5], 1'b1);
    chk("R7", "pin 6 still counting", filt_out[6], 1'b0);
    @(posedge clk); @(negedge clk);
    chk("R7", "pin 6 qualified", filt_out[6], 1'b1);
    tick(1); raw_in[7:4] = '0;
    tick(6);

    cur_req = "R8";
    raw_in[2] = 1'b1;
    wr(3'd4, 32'd2);
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R8", "pin 2 keeps old period", filt_out[2], 1'b0);
    @(posedge clk); @(negedge clk);
    chk("R8", "pin 2 after eight edges", filt_out[2], 1'b1);
    tick(1); raw_in[2] = 1'b0;
    repeat (1) @(posedge clk);
    @(negedge clk);
    chk("R8", "new period for next count", filt_out[2], 1'b1);
    @(posedge clk); @(negedge clk);
    chk("R8", "new period two edges", filt_out[2], 1'b0);
    tick(2);

    cur_req = "R6";
    wr(3'd2, 32'd0);
    raw_in[0] = 1'b1;
    @(negedge clk);
    chk("R6", "period 0 before edge", filt_out[0], 1'b0);
    @(posedge clk); @(negedge clk);
    chk("R6", "period 0 after one edge", filt_out[0], 1'b1);
    wr(3'd2, 32'd1);
    raw_in[0] = 1'b0;
    @(negedge clk);
    chk("R6", "period 1 before edge", filt_out[0], 1'b1);
    @(posedge clk); @(negedge clk);
    chk("R6", "period 1 after one edge", filt_out[0], 1'b0);
    tick(2);

    cur_req = "R9";
    wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    raw_in[8] = 1'b1; raw_in[0] = 1'b1;
    @(negedge clk);
    chk("R9", "pin 8 still bypassed", filt_out[8], 1'b1);
    @(posedge clk); @(negedge clk);
    chk("R9", "period 1 unchanged", filt_out[0], 1'b1);
    raw_in[1] = 1'b1;
    tick(2);
    @(negedge clk);
    chk("R9", "period 2 unchanged", filt_out[1], 1'b0);
    @(posedge clk); @(negedge clk);
    chk("R9", "period 2 unchanged qualifies", filt_out[1], 1'b1);

    cur_req = "R4";
    for (int i = 0; i < 3000; i++) begin
      tick(1);
      raw_in = raw_in ^ ($urandom & $urandom & $urandom);
      if (($urandom % 16) == 0) begin
        logic [2:0] a;
        a = 3'($urandom % 8);
        wr_en = 1'b1; wr_addr = a;
        wr_data = (a >= 3'd2) ? ($urandom % 10) : $urandom;
      end else begin
        wr_en = 1'b0;
      end
    end
    tick(1); wr_en = 1'b0;
    tick(4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule